// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Decimal Adjust

This block is the combinational datapath of a small accumulator machine. Each evaluation takes the accumulator value, a second operand (from memory or an immediate field), the carry and half-carry flags and a four-bit operation code. It returns the new accumulator value and the new carry and half-carry flags. Whatever holds the accumulator and flags registers these outputs. Decode, operand fetch and skip logic sit outside the block.

The operations fall into three groups, each handled by its own submodule:

- The arithmetic group covers plain add, add with carry, subtract with carry, clear, increment and decrement. Subtraction treats carry as an inverted borrow.
- The logic and shift group covers AND, OR, XOR, rotate through carry in either direction and nibble swap.
- The decimal adjust unit corrects a packed-BCD sum or difference. A mode input tells it whether the previous arithmetic step was an addition or a subtraction.

The block has no states: it is a single combinational function of its inputs. Every operation code is named in the requirements below.

Top module: `acc_alu`

## Requirements
- R1: Code 0 (plain add) gives acc + opnd modulo 256 and returns both flags unchanged.
- R2: Code 1 (add with carry) gives acc + opnd + C modulo 256. The new C is the carry out of bit 7 and the new HC is the carry out of bit 3.
- R3: Code 2 (subtract with carry) gives acc - opnd - (1 - C) modulo 256. The new C is 1 when there is no borrow out of bit 7, and the new HC is 1 when there is no borrow out of bit 3.
- R4: Codes 3, 4 and 5 give the bitwise AND, OR and XOR of acc and opnd, and return both flags unchanged.
- R5: Code 6 gives 0. Code 7 gives acc + 1 and code 8 gives acc - 1, both wrapping modulo 256. All three return both flags unchanged.
- R6: Code 9 rotates right through carry: the result is {C, acc[7:1]}, the new C is acc[0] and HC is unchanged.
- R7: Code 10 rotates left through carry: the result is {acc[6:0], C}, the new C is acc[7] and HC is unchanged.
- R8: Code 11 gives {acc[3:0], acc[7:4]} and returns both flags unchanged.
- R9: Code 12 with dadj_sub = 0 adds 0x06 when HC = 1 or acc[3:0] > 9. It also adds 0x60 when C = 1 or acc > 0x99. The new C is the old C OR whether 0x60 was added, and HC is unchanged.
- R10: Code 12 with dadj_sub = 1 subtracts 0x06 when HC = 0 and subtracts 0x60 when C = 0. Both flags are unchanged.
- R11: Code 13 forces C and HC to 1 and code 14 forces both to 0. For both codes the result equals acc.
- R12: Code 15 is unassigned: the result equals acc and both flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0 to 15, see requirements) |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Second operand |
| c_in | input | 1 | Current carry flag |
| hc_in | input | 1 | Current half-carry flag |
| dadj_sub | input | 1 | Decimal adjust mode: 1 after a subtract, 0 after an add |
| res_out | output | 8 | New accumulator value |
| c_out | output | 1 | New carry flag |
| hc_out | output | 1 | New half-carry flag |

## Verification
The bench builds the block with its default digit width of 4, which gives the 8-bit, two-digit datapath. That width lets the bench sweep every operation code over a grid of operand values near the nibble and byte boundaries. It also lets it chain add-with-carry or subtract-with-carry results into decimal adjust, so that real BCD arithmetic covers both correction paths and the carry out of the high digit.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDC  = 4'd1,
        OP_SUBC  = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_XOR   = 4'd5,
        OP_CLR   = 4'd6,
        OP_INC   = 4'd7,
        OP_DEC   = 4'd8,
        OP_RRC   = 4'd9,
        OP_RLC   = 4'd10,
        OP_SWAP  = 4'd11,
        OP_DADJ  = 4'd12,
        OP_SETC  = 4'd13,
        OP_CLRC  = 4'd14,
        OP_NONE  = 4'd15
    } alu_op_e;

endpackage

// File: rtl/aa_arith.sv
module aa_arith
    import acc_alu_pkg::*;
#(
    parameter int DIG_W = 4
) (
    input  alu_op_e                op,
    input  logic [2*DIG_W-1:0]     a,
    input  logic [2*DIG_W-1:0]     b,
    input  logic                   c,
    output logic [2*DIG_W-1:0]     res,
    output logic                   co,
    output logic                   hco
);
    localparam int DATA_W = 2 * DIG_W;

    logic [DATA_W-1:0] b_eff;
    logic              cin;
    logic [DIG_W:0]    lo_sum;
    logic [DATA_W:0]   full_sum;

    always_comb begin
        b_eff = b;
        cin   = 1'b0;
        unique case (op)
            OP_ADDC: begin b_eff = b;  cin = c; end
            OP_SUBC: begin b_eff = ~b; cin = c; end
            OP_INC:  begin b_eff = {{(DATA_W-1){1'b0}}, 1'b1}; end
            OP_DEC:  begin b_eff = {DATA_W{1'b1}}; end
            default: begin b_eff = b; cin = 1'b0; end
        endcase
    end

    assign lo_sum   = {1'b0, a[DIG_W-1:0]} + {1'b0, b_eff[DIG_W-1:0]}
                    + {{DIG_W{1'b0}}, cin};
    assign full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};

    assign res = (op == OP_CLR) ? '0 : full_sum[DATA_W-1:0];
    assign co  = full_sum[DATA_W];
    assign hco = lo_sum[DIG_W];

endmodule

// File: rtl/aa_logic.sv
module aa_logic
    import acc_alu_pkg::*;
#(
    parameter int DIG_W = 4
) (
    input  alu_op_e                op,
    input  logic [2*DIG_W-1:0]     a,
    input  logic [2*DIG_W-1:0]     b,
    input  logic                   c,
    output logic [2*DIG_W-1:0]     res,
    output logic                   co
);
    localparam int DATA_W = 2 * DIG_W;

    always_comb begin
        res = a;
        co  = c;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_RRC:  begin res = {c, a[DATA_W-1:1]}; co = a[0]; end
            OP_RLC:  begin res = {a[DATA_W-2:0], c}; co = a[DATA_W-1]; end
            OP_SWAP: res = {a[DIG_W-1:0], a[DATA_W-1:DIG_W]};
            default: begin res = a; co = c; end
        endcase
    end

endmodule

// File: rtl/aa_dec_adj.sv
module aa_dec_adj #(
    parameter int DIG_W = 4
) (
    input  logic [2*DIG_W-1:0]     a,
    input  logic                   c,
    input  logic                   hc,
    input  logic                   sub,
    output logic [2*DIG_W-1:0]     res,
    output logic                   co
);
    localparam int DATA_W = 2 * DIG_W;
    localparam logic [DIG_W-1:0]  DIG_MAX = DIG_W'(9);
    localparam logic [DIG_W-1:0]  DIG_FIX = DIG_W'(6);
    localparam logic [DATA_W-1:0] BYTE_MAX = {DIG_MAX, DIG_MAX};

    logic              lo_fix;
    logic              hi_fix;
    logic [DATA_W-1:0] corr;

    always_comb begin
        if (sub) begin
            lo_fix = !hc;
            hi_fix = !c;
        end else begin
            lo_fix = hc || (a[DIG_W-1:0] > DIG_MAX);
            hi_fix = c  || (a > BYTE_MAX);
        end
        corr = {(hi_fix ? DIG_FIX : '0), (lo_fix ? DIG_FIX : '0)};
        res  = sub ? (a - corr) : (a + corr);
        co   = sub ? c : (c | hi_fix);
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DIG_W = 4
) (
    input  logic [3:0]             op_sel,
    input  logic [2*DIG_W-1:0]     acc_in,
    input  logic [2*DIG_W-1:0]     opnd_in,
    input  logic                   c_in,
    input  logic                   hc_in,
    input  logic                   dadj_sub,
    output logic [2*DIG_W-1:0]     res_out,
    output logic                   c_out,
    output logic                   hc_out
);
    localparam int DATA_W = 2 * DIG_W;

    alu_op_e           op;
    logic [DATA_W-1:0] ar_res, lg_res, da_res;
    logic              ar_c, ar_hc, lg_c, da_c;

    assign op = alu_op_e'(op_sel);

    aa_arith #(.DIG_W(DIG_W)) u_arith (
        .op(op), .a(acc_in), .b(opnd_in), .c(c_in),
        .res(ar_res), .co(ar_c), .hco(ar_hc)
    );

    aa_logic #(.DIG_W(DIG_W)) u_logic (
        .op(op), .a(acc_in), .b(opnd_in), .c(c_in),
        .res(lg_res), .co(lg_c)
    );

    aa_dec_adj #(.DIG_W(DIG_W)) u_dadj (
        .a(acc_in), .c(c_in), .hc(hc_in), .sub(dadj_sub),
        .res(da_res), .co(da_c)
    );

    always_comb begin
        res_out = acc_in;
        c_out   = c_in;
        hc_out  = hc_in;
        unique case (op)
            OP_ADD, OP_CLR, OP_INC, OP_DEC: res_out = ar_res;
            OP_ADDC, OP_SUBC: begin
                res_out = ar_res;
                c_out   = ar_c;
                hc_out  = ar_hc;
            end
            OP_AND, OP_OR, OP_XOR, OP_SWAP: res_out = lg_res;
            OP_RRC, OP_RLC: begin
                res_out = lg_res;
                c_out   = lg_c;
            end
            OP_DADJ: begin
                res_out = da_res;
                c_out   = da_c;
            end
            OP_SETC: begin c_out = 1'b1; hc_out = 1'b1; end
            OP_CLRC: begin c_out = 1'b0; hc_out = 1'b0; end
            default: begin
                res_out = acc_in;
                c_out   = c_in;
                hc_out  = hc_in;
            end
        endcase
    end

    logic inputs_known;
    assign inputs_known = !$isunknown({op_sel, acc_in, opnd_in, c_in, hc_in, dadj_sub});

    always_comb begin
        if (inputs_known) begin
            // R1
            flag_hold_chk: assert (!(op inside {OP_ADD, OP_AND, OP_OR, OP_XOR, OP_CLR,
                                               OP_INC, OP_DEC, OP_SWAP, OP_NONE})
                                   || (c_out == c_in && hc_out == hc_in));
            // R11
            setc_chk: assert (op != OP_SETC || (c_out && hc_out && res_out == acc_in));
            // R11
            clrc_chk: assert (op != OP_CLRC || (!c_out && !hc_out && res_out == acc_in));
            // R6
            rrc_chk: assert (op != OP_RRC || (c_out == acc_in[0] && res_out[DATA_W-1] == c_in
                                              && hc_out == hc_in));
            // R7
            rlc_chk: assert (op != OP_RLC || (c_out == acc_in[DATA_W-1] && res_out[0] == c_in
                                              && hc_out == hc_in));
            // R5
            clr_chk: assert (op != OP_CLR || res_out == '0);
            // R10
            dadj_sub_chk: assert (op != OP_DADJ || !dadj_sub
                                  || (c_out == c_in && hc_out == hc_in));
        end
    end

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = 4'd0;
    logic [7:0] acc_in = 8'd0, opnd_in = 8'd0;
    logic       c_in = 1'b0, hc_in = 1'b0, dadj_sub = 1'b0;
    logic [7:0] res_out;
    logic       c_out, hc_out;
    logic [7:0] res_q;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    acc_alu u_dut (
        .op_sel(op_sel), .acc_in(acc_in), .opnd_in(opnd_in),
        .c_in(c_in), .hc_in(hc_in), .dadj_sub(dadj_sub),
        .res_out(res_out), .c_out(c_out), .hc_out(hc_out)
    );

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) res_q <= 8'd0;
        else        res_q <= res_out;

    // Reference model built from the requirements: returns {res, c, hc}
    function automatic logic [9:0] model(input int op, input int a, input int b,
                                         input int c, input int hc, input int sub);
        int r, nc, nh, lo, corr;
        r = a; nc = c; nh = hc;
        case (op)
            0:  r = (a + b) % 256;
            1:  begin r = (a + b + c) % 256; nc = (a + b + c) / 256;
                      nh = ((a % 16) + (b % 16) + c) / 16; end
            2:  begin r = (a - b - (1 - c) + 512) % 256;
                      nc = (a - b - (1 - c) >= 0) ? 1 : 0;
                      nh = ((a % 16) - (b % 16) - (1 - c) >= 0) ? 1 : 0; end
            3:  r = a & b;
            4:  r = a | b;
            5:  r = a ^ b;
            6:  r = 0;
            7:  r = (a + 1) % 256;
            8:  r = (a + 255) % 256;
            9:  begin r = c * 128 + a / 2; nc = a % 2; end
            10: begin r = (a * 2) % 256 + c; nc = a / 128; end
            11: r = (a % 16) * 16 + a / 16;
            12: begin
                corr = 0;
                if (sub != 0) begin
                    if (hc == 0) corr += 6;
                    if (c == 0)  corr += 96;
                    r = (a - corr + 256) % 256;
                end else begin
                    lo = a % 16;
                    if (hc == 1 || lo > 9) corr += 6;
                    if (c == 1 || a > 153) begin corr += 96; nc = 1; end
                    r = (a + corr) % 256;
                end
            end
            13: begin nc = 1; nh = 1; end
            14: begin nc = 0; nh = 0; end
            default: ;
        endcase
        return {r[7:0], nc[0], nh[0]};
    endfunction

    task automatic apply(input int op, input int a, input int b, input int c,
                         input int hc, input int sub);
        @(negedge clk);
        op_sel = op[3:0]; acc_in = a[7:0]; opnd_in = b[7:0];
        c_in = c[0]; hc_in = hc[0]; dadj_sub = sub[0];
        @(posedge clk); #2;
    endtask

    task automatic check(input string req, input int op, input int a, input int b,
                         input int c, input int hc, input int sub);
        logic [9:0] e;
        apply(op, a, b, c, hc, sub);
        e = model(op, a, b, c, hc, sub);
        n_run++;
        if ({res_out, c_out, hc_out} !== e) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h c=%0d hc=%0d: got res=%h c=%b hc=%b exp res=%h c=%b hc=%b",
                     req, op, a, b, c, hc, res_out, c_out, hc_out, e[9:2], e[1], e[0]);
        end
    endtask

    task automatic check_val(input string req, input logic [9:0] got, input logic [9:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic sweep(input string req, input int op, input int sub);
        int vals[8] = '{8'h00, 8'h01, 8'h09, 8'h0F, 8'h7F, 8'h80, 8'h9A, 8'hFF};
        foreach (vals[i])
            for (int j = 0; j < 8; j += 3)
                for (int f = 0; f < 4; f++)
                    check(req, op, vals[i], vals[(i + j) % 8], f / 2, f % 2, sub);
    endtask

    task automatic t_reset();
        check_val("R1 reset", {res_q, 2'b00}, 10'd0);
    endtask

    task automatic t_add();   sweep("R1", 0, 0); check("R1", 0, 8'hF0, 8'h20, 1, 1, 0); endtask
    task automatic t_adc();   sweep("R2", 1, 0); check("R2", 1, 8'h0F, 8'h00, 1, 0, 0); endtask
    task automatic t_subc();  sweep("R3", 2, 0); check("R3", 2, 8'h10, 8'h01, 1, 1, 0); endtask
    task automatic t_logic(); sweep("R4", 3, 0); sweep("R4", 4, 0); sweep("R4", 5, 0); endtask
    task automatic t_incdec(); sweep("R5", 6, 0); sweep("R5", 7, 0); sweep("R5", 8, 0); endtask
    task automatic t_rrc();   sweep("R6", 9, 0); endtask
    task automatic t_rlc();   sweep("R7", 10, 0); endtask
    task automatic t_swap();  sweep("R8", 11, 0); endtask

    task automatic t_dadj_add();
        sweep("R9", 12, 0);
        // 15 + 27 = 42 in BCD
        apply(1, 8'h15, 8'h27, 0, 0, 0);
        check("R9", 12, res_out, 0, c_out, hc_out, 0);
        check_val("R9 bcd 15+27", {res_out, c_out, 1'b0}, {8'h42, 2'b00});
        // 99 + 01 = 100 in BCD
        apply(1, 8'h99, 8'h01, 0, 0, 0);
        check("R9", 12, res_out, 0, c_out, hc_out, 0);
        check_val("R9 bcd 99+01", {res_out, c_out, 1'b0}, {8'h00, 2'b10});
    endtask

    task automatic t_dadj_sub();
        sweep("R10", 12, 1);
        // 42 - 15 = 27 in BCD
        apply(2, 8'h42, 8'h15, 1, 0, 0);
        check("R10", 12, res_out, 0, c_out, hc_out, 1);
        check_val("R10 bcd 42-15", {res_out, c_out, 1'b0}, {8'h27, 2'b10});
        // 15 - 27 = 88 with borrow
        apply(2, 8'h15, 8'h27, 1, 0, 0);
        check("R10", 12, res_out, 0, c_out, hc_out, 1);
        check_val("R10 bcd 15-27", {res_out, c_out, 1'b0}, {8'h88, 2'b00});
    endtask

    task automatic t_setclr(); sweep("R11", 13, 0); sweep("R11", 14, 0); endtask
    task automatic t_unused(); sweep("R12", 15, 0); endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_add(); t_adc(); t_subc(); t_logic(); t_incdec();
        t_rrc(); t_rlc(); t_swap(); t_dadj_add(); t_dadj_sub();
        t_setclr(); t_unused();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog expired: got=running exp=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule